// File: doc/BRIEF.md
# Auto-Incrementing Color Palette Access Port

This block gives a processor byte-wide register access to a 128-byte color palette memory. The palette has two 64-byte halves: background colors at offsets 0 to 63 and object colors at offsets 64 to 127. Each half is reached through two registers. The pointer register selects a byte within that half. The value register reads or writes the byte that the pointer selects.

Software loads a pointer. It can then stream color bytes through the value register. If the pointer's step bit is set, each stored byte advances the pointer, so a whole half can be filled with back-to-back writes. The two halves keep separate pointers and behave the same way. All 128 bytes are always visible on a flat output, so downstream color logic can read them directly.

The register interface is a plain select, write strobe and write data. There is no handshake, and every write completes in one cycle. A read has no side effects: `rd_data` is a combinational view of the selected register.

Top module: `color_palette_port`

## Requirements
- R1: After reset, all 128 palette bytes are zero and both pointers read back as 0x00.
- R2: Select encoding is 0 = background pointer, 1 = background value, 2 = object pointer, 3 = object value. A write to a pointer keeps bit 7 (step enable) and bits 5:0 (offset) of the written byte and clears bit 6. Bit 6 of a pointer therefore always reads back as 0.
- R3: A write to a value register stores the byte at palette offset base + pointer[5:0]. The base is 0 for background and 64 for object. Palette byte k appears on `palette_flat[8k+7:8k]`.
- R4: After a value write with pointer bit 7 set, that pointer becomes {1, 0, (offset + 1) mod 64}. The offset wraps from 63 to 0 and bit 7 is kept.
- R5: After a value write with pointer bit 7 clear, that pointer is unchanged.
- R6: Reading a value select returns the palette byte at the current pointer. This holds in the cycle right after a pointer write. A cycle without a write changes no pointer and no palette byte.
- R7: The two halves are independent. Writes to one half's registers never change the other half's pointer or bytes.
- R8: Reading a pointer select returns the stored pointer value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select (see R2) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Combinational read of the selected register |
| palette_flat | output | 1024 | All 128 palette bytes, byte k at bits 8k+7:8k |

## Verification
The bench goes after the pointer wrap from offset 63 back to 0. A design that carried into bit 6 there would read back 0xC0 and then write into the wrong byte. It writes pointer values with bit 6 set to catch a design that stores that bit. It also re-reads a value select right after a pointer write to catch a stale value view. It interleaves background and object accesses, so a shared pointer or a missing 64-byte offset would corrupt the other half's bytes on the flat output.

// File: rtl/cpal_pkg.sv
package cpal_pkg;
  typedef enum logic [1:0] {
    SEL_BG_PTR  = 2'd0,
    SEL_BG_VAL  = 2'd1,
    SEL_OBJ_PTR = 2'd2,
    SEL_OBJ_VAL = 2'd3
  } cpal_sel_e;

  localparam int unsigned NUM_HALVES = 2;
endpackage

// File: rtl/cpal_half.sv
module cpal_half #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we,
  input  logic              val_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ptr_q,
  output logic [OFS_W-1:0]  ofs
);
  logic [DATA_W-1:0] ptr_d;
  logic [OFS_W-1:0]  ofs_inc;

  assign ofs_inc = ptr_q[OFS_W-1:0] + OFS_W'(1);

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_we) begin
      ptr_d                = '0;
      ptr_d[DATA_W-1]      = wr_data[DATA_W-1];
      ptr_d[OFS_W-1:0]     = wr_data[OFS_W-1:0];
    end else if (val_we && ptr_q[DATA_W-1]) begin
      ptr_d                = '0;
      ptr_d[DATA_W-1]      = 1'b1;
      ptr_d[OFS_W-1:0]     = ofs_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ofs = ptr_q[OFS_W-1:0];
endmodule

// File: rtl/cpal_store.sv
module cpal_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [DATA_W-1:0]       rdata,
  output logic [DEPTH*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem[k] <= '0;
      else if (we && waddr == ADDR_W'(k))   mem[k] <= wdata;
    end
    assign flat[k*DATA_W +: DATA_W] = mem[k];
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/color_palette_port.sv
module color_palette_port #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned HALF_DEPTH = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     reg_sel,
  input  logic                           wr_en,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [DATA_W-1:0]              rd_data,
  output logic [2*HALF_DEPTH*DATA_W-1:0] palette_flat
);
  import cpal_pkg::*;

  localparam int unsigned OFS_W  = $clog2(HALF_DEPTH);
  localparam int unsigned DEPTH  = NUM_HALVES * HALF_DEPTH;
  localparam int unsigned ADDR_W = OFS_W + 1;

  logic [DATA_W-1:0] ptr_q [NUM_HALVES];
  logic [OFS_W-1:0]  ofs   [NUM_HALVES];
  logic              half_sel;
  logic              is_val;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] mem_rd;

  assign half_sel = reg_sel[1];
  assign is_val   = reg_sel[0];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic hit;
    assign hit = wr_en && (half_sel == 1'(h));
    cpal_half #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_half (
      .clk     (clk),
      .rst_n   (rst_n),
      .ptr_we  (hit && !is_val),
      .val_we  (hit && is_val),
      .wr_data (wr_data),
      .ptr_q   (ptr_q[h]),
      .ofs     (ofs[h])
    );
  end

  assign addr = {half_sel, ofs[half_sel]};

  cpal_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en && is_val),
    .waddr (addr),
    .wdata (wr_data),
    .raddr (addr),
    .rdata (mem_rd),
    .flat  (palette_flat)
  );

  assign rd_data = is_val ? mem_rd : ptr_q[half_sel];
endmodule

// File: rtl/cpal_checker.sv
module cpal_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFS_W  = 6,
  parameter int unsigned FLAT_W = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_sel,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [FLAT_W-1:0] palette_flat,
  input logic [DATA_W-1:0] bg_ptr,
  input logic [DATA_W-1:0] obj_ptr
);
  localparam logic [DATA_W-1:0] KEEP =
    (DATA_W'(1) << (DATA_W-1)) | ((DATA_W'(1) << OFS_W) - DATA_W'(1));

  assert_bg_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd0) |=> bg_ptr == ($past(wr_data) & KEEP));
  assert_obj_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd2) |=> obj_ptr == ($past(wr_data) & KEEP));
  assert_ptr_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (rd_data == bg_ptr && !rd_data[DATA_W-2]));
  assert_bg_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd1 && bg_ptr[DATA_W-1]) |=>
    (bg_ptr[DATA_W-1] && bg_ptr[OFS_W-1:0] == $past(bg_ptr[OFS_W-1:0]) + OFS_W'(1)));
  assert_obj_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd3 && obj_ptr[DATA_W-1]) |=>
    (obj_ptr[DATA_W-1] && obj_ptr[OFS_W-1:0] == $past(obj_ptr[OFS_W-1:0]) + OFS_W'(1)));
  assert_bg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd1 && !bg_ptr[DATA_W-1]) |=> $stable(bg_ptr));
  assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd1 && !bg_ptr[DATA_W-1]) |=>
    (reg_sel != 2'd1 || rd_data == $past(wr_data)));
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(bg_ptr) && $stable(obj_ptr) && $stable(palette_flat)));
  assert_bg_indep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel[1]) |=> $stable(obj_ptr));
  assert_obj_indep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel[1]) |=> $stable(bg_ptr));
endmodule

bind color_palette_port cpal_checker #(
  .DATA_W (DATA_W),
  .OFS_W  (OFS_W),
  .FLAT_W (2*HALF_DEPTH*DATA_W)
) u_cpal_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_sel      (reg_sel),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .palette_flat (palette_flat),
  .bg_ptr       (ptr_q[0]),
  .obj_ptr      (ptr_q[1])
);

// File: tb/tb_color_palette_port.sv
`timescale 1ns/100ps
module tb_color_palette_port;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   reg_sel = 2'd0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_data = 8'd0;
  logic [7:0]   rd_data;
  logic [1023:0] palette_flat;

  int unsigned  n_chk = 0;
  int unsigned  n_bad = 0;
  bit           done = 1'b0;
  byte unsigned pal [128];
  int           ptr [2];

  color_palette_port dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .palette_flat(palette_flat)
  );

  always #2 clk = ~clk;

  function automatic int exp_rd(input logic [1:0] s);
    case (s)
      2'd0:    return ptr[0];
      2'd1:    return pal[ptr[0] & 63];
      2'd2:    return ptr[1];
      default: return pal[64 + (ptr[1] & 63)];
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // reference model, updated after each edge, then compared every clock
  always @(posedge clk) begin
    #0.5;
    if (!rst_n) begin
      foreach (pal[k]) pal[k] = 8'h00;
      ptr[0] = 0; ptr[1] = 0;
    end else if (wr_en) begin
      automatic int h = reg_sel[1];
      if (!reg_sel[0]) ptr[h] = wr_data & 8'hBF;
      else begin
        pal[h*64 + (ptr[h] & 63)] = wr_data;
        if (ptr[h] & 8'h80) ptr[h] = (ptr[h] + 1) & 8'hBF;
      end
    end
    #0.5;
    begin
      automatic int bad_b = -1;
      for (int k = 0; k < 128; k++)
        if (palette_flat[k*8 +: 8] != pal[k] && bad_b < 0) bad_b = k;
      if (bad_b >= 0) check("R3/R7 byte", palette_flat[bad_b*8 +: 8], pal[bad_b]);
      else            check("R3", 0, 0);
    end
    check(reg_sel[0] ? "R6 value read" : "R8 pointer read", rd_data, exp_rd(reg_sel));
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, input string req, input int exp);
    @(negedge clk); wr_en = 1'b0; reg_sel = s; #0.5;
    check(req, rd_data, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 palette", (palette_flat == '0) ? 1 : 0, 1);
    peek(2'd0, "R1 bg pointer", 0);
    peek(2'd2, "R1 obj pointer", 0);
    rst_n = 1'b1;
    // R2: bit 6 dropped on load
    wr(2'd0, 8'h7F);  peek(2'd0, "R2 bit6 clear", 8'h3F);
    // R4: fill background with stepping, crossing the wrap
    wr(2'd0, 8'h80);
    for (int i = 0; i < 70; i++) wr(2'd1, 8'(i + 8'h11));
    peek(2'd0, "R4 wrap bg", 8'h86);
    peek(2'd2, "R7 obj untouched", 0);
    // R4: wrap from offset 63 with bit 6 set in the write
    wr(2'd2, 8'hFF);  peek(2'd2, "R2 obj load", 8'hBF);
    wr(2'd3, 8'hA5);  peek(2'd2, "R4 63 to 0", 8'h80);
    wr(2'd3, 8'h5A);  peek(2'd2, "R4 step", 8'h81);
    // R5: no step, overwrite same byte
    wr(2'd2, 8'h05); wr(2'd3, 8'h33); wr(2'd3, 8'h44);
    peek(2'd2, "R5 hold", 8'h05);
    peek(2'd3, "R3 obj value", 8'h44);
    // R6: value view follows a pointer write at once
    wr(2'd0, 8'h02);  peek(2'd1, "R6 refresh", pal[2]);
    wr(2'd2, 8'h3F);  peek(2'd3, "R6 refresh obj", 8'hA5);
    repeat (4) peek(2'd1, "R6 read no step", pal[2]);
    peek(2'd0, "R6 pointer stable", 8'h02);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      reg_sel = 2'($urandom);
      wr_en   = 1'($urandom);
      wr_data = 8'($urandom);
    end
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule